// File: doc/BRIEF.md
# Programmable 24-bit Counter/Timer Channel

This block is one counter/timer channel with a 24-bit count, reached through four 16-bit word registers on a simple synchronous read/write strobe. The count advances on quadrature encoder edges (A, B and an index input) or on an internal tick enable. It decodes encoders at single, double or quadruple resolution. Together with two preload values and a capture/output flag, it can also produce one-shot pulses and continuous pulse trains on a single output pin.

Software picks the behaviour with a 16-bit mode word. The mode word sets the clock source, the direction source, the count-enable gating, the reload trigger, the active preload bank, the latch behaviour and the output selection. Writes to the control word issue immediate commands: clear the count, load it from the first preload, or clear the flag. The count is read as a low word and then a high word. Reading the low word captures the upper byte, so the pair stays consistent.

Top module: `cnt24_channel`

## Requirements
- R1: After a synchronous reset, the count, both preloads, the mode word, the latch and the flag are zero, and `cnt_out` is 0.
- R2: The register address map is 0 = data low, 1 = data high, 2 = mode, 3 = control. A write to address 0 sets bits 15:0 of the preload chosen by mode bit 14 (0 = first, 1 = second). A write to address 1 sets bits 23:16 of that preload from write bits 7:0.
- R3: A read strobe at address 0 returns count bits 15:0 and captures count bits 23:16 into the latch. At address 1 the read data holds the latch in bits 7:0 when mode bit 13 is 0, or the live count bits 23:16 when bit 13 is 1. Bits 15:8 at address 1 are always 0. Address 2 returns the mode word and address 3 returns 0.
- R4: Mode bits 10:9 select the count clock. Value 0 counts A rising edges (x1), 1 counts every A edge (x2) and 2 counts every A or B edge (x4). When mode bit 12 is 0, the count goes up when A leads B and down when B leads A. When bit 12 is 1, the direction comes from bit 11 (1 = down).
- R5: A, B and the index pass through two synchronizing flops before edge detection, so an encoder edge changes the count on the third clock edge after it. A cycle in which A and B both change does not move the count.
- R6: Clock source 3 counts one step on every clock edge where `tick_en` is 1, with the direction taken from mode bit 11.
- R7: Mode bits 8:7 gate counting: 0 = never, 1 = always, 2 = by the hardware source in bits 6:5. The hardware source values are 0 = always, 1 = synchronized index level, 2 = flag, 3 = inverted flag.
- R8: Control bit 15 clears the count, bit 14 loads the count from the first preload, and bit 3 clears the flag. In any one cycle, clear beats load, and both beat an index reload and a count step. A flag clear beats a flag update from terminal count.
- R9: With reload field bits 4:2 = 4, a rising edge of the synchronized index loads the count from the first preload. Any other reload value leaves the index without effect on the count.
- R10: Terminal count is a count step taken from 0 downward or from 0xFFFFFF upward. Reload value 1 toggles the flag and reloads the second preload if the flag becomes 1, or the first preload if it becomes 0. Reload value 2 sets the flag and reloads the first preload. Every other value sets the flag and wraps the count.
- R11: `cnt_out` is the flag when mode bit 0 is 0, or a one-clock terminal-count pulse when bit 0 is 1. Mode bit 1 inverts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; at address 0 it captures the upper byte |
| bus_addr | input | 2 | Word register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder index, asynchronous |
| tick_en | input | 1 | Internal clock enable for clock source 3 |
| cnt_out | output | 1 | Counter output pin |

## Verification
Two pairs of events can land in the same clock edge. A control write (load or flag clear) can meet a count step that is a terminal count. A control write can also meet an index reload. The bench runs a pulse train from the tick input and issues load commands at a sweep of cycle offsets, so some of them meet a reload edge exactly. A behavioural model built from the priority rules judges the count, the flag-driven output and the read data on every clock. Directed checks also measure the pulse lengths in clock cycles.

// File: rtl/cnt24_pkg.sv
package cnt24_pkg;

    localparam int CNT_W = 24;
    localparam int BUS_W = 16;

    localparam logic [1:0] ADDR_LO   = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd1;
    localparam logic [1:0] ADDR_MODE = 2'd2;
    localparam logic [1:0] ADDR_CTRL = 2'd3;

    localparam int CTL_CLR_BIT  = 15;
    localparam int CTL_LOAD_BIT = 14;
    localparam int CTL_FLAG_BIT = 3;

    localparam logic [2:0] RL_TOGGLE  = 3'd1;
    localparam logic [2:0] RL_ONESHOT = 3'd2;
    localparam logic [2:0] RL_INDEX   = 3'd4;

    localparam logic [1:0] EN_OFF = 2'd0;
    localparam logic [1:0] EN_ON  = 2'd1;
    localparam logic [1:0] EN_HW  = 2'd2;

    typedef enum logic [1:0] {
        CS_X1   = 2'd0,
        CS_X2   = 2'd1,
        CS_X4   = 2'd2,
        CS_TICK = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic       rsvd;
        logic       bank_sel;
        logic       hi_live;
        logic       dir_sw;
        logic       dir_down;
        clk_src_e   clk_src;
        logic [1:0] en_ctl;
        logic [1:0] hw_src;
        logic [2:0] reload;
        logic       out_inv;
        logic       out_tc;
    } mode_t;

    function automatic logic hw_gate(input logic [1:0] sel, input logic idx_lvl,
                                     input logic flag);
        case (sel)
            2'd0:    hw_gate = 1'b1;
            2'd1:    hw_gate = idx_lvl;
            2'd2:    hw_gate = flag;
            default: hw_gate = ~flag;
        endcase
    endfunction

endpackage

// File: rtl/cnt24_qdec.sv
module cnt24_qdec
    import cnt24_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enc_a,
    input  logic     enc_b,
    input  logic     enc_idx,
    input  logic     tick_en,
    input  clk_src_e mult,
    output logic     ev,
    output logic     q_up,
    output logic     idx_lvl,
    output logic     idx_rise
);
    // stage vectors are {idx, b, a}
    logic [2:0] sync1, sync2, prev;
    logic a_chg, b_chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
        end else begin
            sync1 <= {enc_idx, enc_b, enc_a};
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    assign a_chg    = sync2[0] ^ prev[0];
    assign b_chg    = sync2[1] ^ prev[1];
    assign idx_lvl  = sync2[2];
    assign idx_rise = sync2[2] & ~prev[2];
    assign q_up     = a_chg ? (sync2[0] != sync2[1]) : (sync2[0] == sync2[1]);

    always_comb begin
        case (mult)
            CS_X1:   ev = a_chg & ~b_chg & sync2[0];
            CS_X2:   ev = a_chg & ~b_chg;
            CS_X4:   ev = a_chg ^ b_chg;
            default: ev = tick_en;
        endcase
    end

    // R5: a cycle with both phases changing must not produce a step
    p_dual_edge_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (a_chg && b_chg && mult != CS_TICK) |-> !ev);

endmodule

// File: rtl/cnt24_core.sv
module cnt24_core
    import cnt24_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    reload,
    input  logic [1:0]    en_ctl,
    input  logic [1:0]    hw_src,
    input  logic          use_sw_dir,
    input  logic          dir_down,
    input  logic [CW-1:0] pr0,
    input  logic [CW-1:0] pr1,
    input  logic          cmd_clr,
    input  logic          cmd_load,
    input  logic          cmd_flag_clr,
    input  logic          ev,
    input  logic          q_up,
    input  logic          idx_lvl,
    input  logic          idx_rise,
    output logic [CW-1:0] count,
    output logic          flag,
    output logic          tc_pulse
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    logic en, step, down, tc, idx_load, cmd_any;

    always_comb begin
        case (en_ctl)
            EN_ON:   en = 1'b1;
            EN_HW:   en = hw_gate(hw_src, idx_lvl, flag);
            default: en = 1'b0;
        endcase
    end

    assign down     = use_sw_dir ? dir_down : ~q_up;
    assign step     = ev & en;
    assign tc       = step & (down ? (count == '0) : (count == MAXV));
    assign idx_load = (reload == RL_INDEX) & idx_rise;
    assign cmd_any  = cmd_clr | cmd_load | idx_load;

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            flag     <= 1'b0;
            tc_pulse <= 1'b0;
        end else begin
            tc_pulse <= 1'b0;
            if (cmd_clr) begin
                count <= '0;
            end else if (cmd_load || idx_load) begin
                count <= pr0;
            end else if (step) begin
                if (tc) begin
                    tc_pulse <= 1'b1;
                    case (reload)
                        RL_TOGGLE:  count <= flag ? pr0 : pr1;
                        RL_ONESHOT: count <= pr0;
                        default:    count <= down ? MAXV : '0;
                    endcase
                end else begin
                    count <= down ? count - 1'b1 : count + 1'b1;
                end
            end

            if (cmd_flag_clr) begin
                flag <= 1'b0;
            end else if (tc && !cmd_any) begin
                flag <= (reload == RL_TOGGLE) ? ~flag : 1'b1;
            end
        end
    end

    p_ctl_clear_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_clr |=> (count == '0));

    p_ctl_load_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_load && !cmd_clr) |=> (count == $past(pr0)));

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_flag_clr |=> !flag);

    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (!step && !cmd_any) |=> $stable(count));

    p_tc_sets_flag_r10: assert property (@(posedge clk) disable iff (rst)
        (tc && !cmd_any && !cmd_flag_clr && reload != RL_TOGGLE) |=> flag);

endmodule

// File: rtl/cnt24_channel.sv
module cnt24_channel
    import cnt24_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_idx,
    input  logic             tick_en,
    output logic             cnt_out
);
    localparam int HI_W = CW - BUS_W;

    mode_t            mode_q;
    logic [CW-1:0]    pr [2];
    logic [HI_W-1:0]  latch_hi;
    logic [CW-1:0]    count;
    logic             flag, tc_pulse;
    logic             ev, q_up, idx_lvl, idx_rise;
    logic             wr_lo, wr_hi, wr_mode, wr_ctrl;
    logic [HI_W-1:0]  hi_view;

    assign wr_lo   = bus_wr && bus_addr == ADDR_LO;
    assign wr_hi   = bus_wr && bus_addr == ADDR_HI;
    assign wr_mode = bus_wr && bus_addr == ADDR_MODE;
    assign wr_ctrl = bus_wr && bus_addr == ADDR_CTRL;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q <= mode_t'(bus_wdata);
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                pr[g] <= '0;
            end else if (mode_q.bank_sel == g[0]) begin
                if (wr_lo) pr[g][BUS_W-1:0] <= bus_wdata;
                if (wr_hi) pr[g][CW-1:BUS_W] <= bus_wdata[HI_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_hi <= '0;
        end else if (bus_rd && bus_addr == ADDR_LO) begin
            latch_hi <= count[CW-1:BUS_W];
        end
    end

    cnt24_qdec u_qdec (
        .clk      (clk),
        .rst      (rst),
        .enc_a    (enc_a),
        .enc_b    (enc_b),
        .enc_idx  (enc_idx),
        .tick_en  (tick_en),
        .mult     (mode_q.clk_src),
        .ev       (ev),
        .q_up     (q_up),
        .idx_lvl  (idx_lvl),
        .idx_rise (idx_rise)
    );

    cnt24_core #(.CW(CW)) u_core (
        .clk          (clk),
        .rst          (rst),
        .reload       (mode_q.reload),
        .en_ctl       (mode_q.en_ctl),
        .hw_src       (mode_q.hw_src),
        .use_sw_dir   (mode_q.dir_sw || mode_q.clk_src == CS_TICK),
        .dir_down     (mode_q.dir_down),
        .pr0          (pr[0]),
        .pr1          (pr[1]),
        .cmd_clr      (wr_ctrl && bus_wdata[CTL_CLR_BIT]),
        .cmd_load     (wr_ctrl && bus_wdata[CTL_LOAD_BIT]),
        .cmd_flag_clr (wr_ctrl && bus_wdata[CTL_FLAG_BIT]),
        .ev           (ev),
        .q_up         (q_up),
        .idx_lvl      (idx_lvl),
        .idx_rise     (idx_rise),
        .count        (count),
        .flag         (flag),
        .tc_pulse     (tc_pulse)
    );

    assign hi_view = mode_q.hi_live ? count[CW-1:BUS_W] : latch_hi;

    always_comb begin
        case (bus_addr)
            ADDR_LO:   bus_rdata = count[BUS_W-1:0];
            ADDR_HI:   bus_rdata = {{(BUS_W-HI_W){1'b0}}, hi_view};
            ADDR_MODE: bus_rdata = mode_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign cnt_out = (mode_q.out_tc ? tc_pulse : flag) ^ mode_q.out_inv;

    p_hi_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_HI) |-> (bus_rdata[BUS_W-1:HI_W] == '0));

    p_reset_out_low_r1: assert property (@(posedge clk)
        rst |=> !cnt_out);

endmodule

// File: tb/cnt24_channel_tb_top.sv
module cnt24_channel_tb_top;

    localparam int MAXV = 24'hFFFFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0, tick_en = 1'b0;
    logic        cnt_out;

    always #2 clk = ~clk;

    cnt24_channel dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .tick_en(tick_en), .cnt_out(cnt_out)
    );

    int    checks = 0, errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int   m_count, m_pr0, m_pr1, m_mode, m_latch_hi;
    bit   m_flag, m_tc;
    logic [2:0] q1, q2, qp;

    always @(posedge clk) begin : model
        int cs, enc, hws, rl, nc;
        bit dsw, ddn, psel, ac, bc, ev, qup, gate, en, dn, step, clr, ld, fc, iload, tc, nf, ntc;
        if (rst) begin
            m_count = 0; m_pr0 = 0; m_pr1 = 0; m_mode = 0; m_latch_hi = 0;
            m_flag = 0; m_tc = 0; q1 = 0; q2 = 0; qp = 0;
        end else begin
            cs   = (m_mode >> 9) & 3;
            enc  = (m_mode >> 7) & 3;
            hws  = (m_mode >> 5) & 3;
            rl   = (m_mode >> 2) & 7;
            dsw  = m_mode[12];
            ddn  = m_mode[11];
            psel = m_mode[14];
            ac   = q2[0] ^ qp[0];
            bc   = q2[1] ^ qp[1];
            if (cs == 3)          ev = tick_en;
            else if (ac && bc)    ev = 0;
            else if (cs == 2)     ev = ac || bc;
            else if (cs == 1)     ev = ac;
            else                  ev = ac && q2[0];
            // forward rotation 00->10->11->01 counts up
            if (ac) qup = (q2[0] != q2[1]); else qup = (q2[0] == q2[1]);
            case (hws)
                0: gate = 1;
                1: gate = q2[2];
                2: gate = m_flag;
                default: gate = !m_flag;
            endcase
            en    = (enc == 1) || (enc == 2 && gate);
            dn    = (dsw || cs == 3) ? ddn : !qup;
            step  = ev && en;
            clr   = bus_wr && bus_addr == 3 && bus_wdata[15];
            ld    = bus_wr && bus_addr == 3 && bus_wdata[14];
            fc    = bus_wr && bus_addr == 3 && bus_wdata[3];
            iload = (rl == 4) && q2[2] && !qp[2];
            tc    = step && (dn ? (m_count == 0) : (m_count == MAXV));
            nc = m_count; nf = m_flag; ntc = 0;
            if (clr) nc = 0;
            else if (ld || iload) nc = m_pr0;
            else if (step) begin
                if (tc) begin
                    ntc = 1;
                    if (rl == 1)      nc = m_flag ? m_pr0 : m_pr1;
                    else if (rl == 2) nc = m_pr0;
                    else              nc = dn ? MAXV : 0;
                end else nc = dn ? m_count - 1 : m_count + 1;
            end
            if (fc) nf = 0;
            else if (tc && !clr && !ld && !iload) nf = (rl == 1) ? !m_flag : 1;
            if (bus_wr && bus_addr == 0) begin
                if (psel) m_pr1 = (m_pr1 & 'hFF0000) | int'(bus_wdata);
                else      m_pr0 = (m_pr0 & 'hFF0000) | int'(bus_wdata);
            end
            if (bus_wr && bus_addr == 1) begin
                if (psel) m_pr1 = (m_pr1 & 'hFFFF) | ((int'(bus_wdata) & 'hFF) << 16);
                else      m_pr0 = (m_pr0 & 'hFFFF) | ((int'(bus_wdata) & 'hFF) << 16);
            end
            if (bus_wr && bus_addr == 2) m_mode = int'(bus_wdata);
            if (bus_rd && bus_addr == 0) m_latch_hi = m_count >> 16;
            m_count = nc; m_flag = nf; m_tc = ntc;
            qp = q2; q2 = q1; q1 = {enc_idx, enc_b, enc_a};
        end
    end

    always @(negedge clk) begin : compare
        int exp_rd;
        bit exp_out;
        if (!rst && !done) begin
            exp_out = (m_mode[0] ? m_tc : m_flag) ^ m_mode[1];
            case (bus_addr)
                2'd0: exp_rd = m_count & 'hFFFF;
                2'd1: exp_rd = m_mode[13] ? (m_count >> 16) : m_latch_hi;
                2'd2: exp_rd = m_mode;
                default: exp_rd = 0;
            endcase
            check({cur_req, " out"}, int'(cnt_out), int'(exp_out));
            check({cur_req, " rdata"}, int'(bus_rdata), exp_rd);
        end
    end

    // ---------------- stimulus helpers (entered at posedge+1) ----------------
    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        @(negedge clk); d = bus_rdata;
        @(posedge clk); #1;
    endtask

    task automatic quad(input logic a, input logic b);
        enc_a = a; enc_b = b;
        idle(4);
    endtask

    task automatic fwd_cycle();
        quad(1, 0); quad(1, 1); quad(0, 1); quad(0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] d;
        int n;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        cur_req = "R1";
        check("R1 out", int'(cnt_out), 0);
        rd(2'd0, d); check("R1 low", int'(d), 0);
        rd(2'd1, d); check("R1 high", int'(d), 0);
        rd(2'd2, d); check("R1 mode", int'(d), 0);

        // R2/R3: preload writes, load command, word readback
        cur_req = "R2";
        wr(2'd0, 16'h3456); wr(2'd1, 16'hAB12);
        wr(2'd3, 16'h4000);
        rd(2'd0, d); check("R2 low", int'(d), 'h3456);
        rd(2'd1, d); check("R3 high", int'(d), 'h0012);
        rd(2'd3, d); check("R3 ctrl read", int'(d), 0);

        // R3/R6: latched upper byte across a tick step
        cur_req = "R3";
        wr(2'd2, 16'h1680);
        wr(2'd0, 16'hFFFF); wr(2'd1, 16'h0012); wr(2'd3, 16'h4000);
        rd(2'd0, d); check("R3 low", int'(d), 'hFFFF);
        tick_en = 1'b1; @(posedge clk); #1 tick_en = 1'b0;
        rd(2'd1, d); check("R3 latched high", int'(d), 'h12);
        wr(2'd2, 16'h3680);
        rd(2'd1, d); check("R3 live high", int'(d), 'h13);
        rd(2'd0, d); check("R6 tick step", int'(d), 0);

        // R8: clear command
        cur_req = "R8";
        wr(2'd3, 16'h8000);
        rd(2'd1, d); check("R8 clear", int'(d), 0);

        // R4: quadrature decoding
        cur_req = "R4";
        wr(2'd2, 16'h2480);
        fwd_cycle(); fwd_cycle();
        peek(2'd0, d); check("R4 x4 fwd", int'(d), 8);
        quad(0, 1); quad(1, 1); quad(1, 0); quad(0, 0);
        peek(2'd0, d); check("R4 x4 rev", int'(d), 4);
        wr(2'd2, 16'h2080);
        fwd_cycle(); fwd_cycle();
        peek(2'd0, d); check("R4 x1 fwd", int'(d), 6);
        wr(2'd2, 16'h2280);
        fwd_cycle();
        peek(2'd0, d); check("R4 x2 fwd", int'(d), 8);
        wr(2'd2, 16'h3C80);
        quad(1, 0); quad(1, 1); quad(0, 1); quad(0, 0);
        peek(2'd0, d); check("R4 sw down", int'(d), 4);

        // R5: simultaneous change ignored, three-edge latency
        cur_req = "R5";
        wr(2'd2, 16'h2480);
        quad(1, 1); quad(0, 0);
        peek(2'd0, d); check("R5 dual edge", int'(d), 4);
        bus_addr = 2'd0;
        enc_a = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R5 before third edge", int'(bus_rdata), 4);
        @(posedge clk); @(negedge clk);
        check("R5 third edge", int'(bus_rdata), 5);
        @(posedge clk); #1;
        quad(0, 0);

        // R9: index reload
        cur_req = "R9";
        wr(2'd2, 16'h2490);
        wr(2'd0, 16'd100); wr(2'd1, 16'h0000);
        enc_idx = 1'b1; idle(5); enc_idx = 1'b0; idle(4);
        peek(2'd0, d); check("R9 index load", int'(d), 100);
        wr(2'd3, 16'h8000); wr(2'd2, 16'h2480);
        enc_idx = 1'b1; idle(5); enc_idx = 1'b0; idle(4);
        peek(2'd0, d); check("R9 index ignored", int'(d), 0);

        // R10/R7/R11: one-shot gated by inverted flag
        cur_req = "R10";
        wr(2'd2, 16'h3F6A);
        wr(2'd0, 16'd5); wr(2'd1, 16'h0000); wr(2'd3, 16'h4000);
        check("R11 inverted flag", int'(cnt_out), 1);
        tick_en = 1'b1; idle(12);
        check("R10 one-shot done", int'(cnt_out), 0);
        peek(2'd0, d); check("R7 stopped and reloaded", int'(d), 5);
        wr(2'd3, 16'h0008);
        n = 0;
        @(negedge clk);
        while (cnt_out === 1'b1 && n < 50) begin n++; @(negedge clk); end
        check("R10 one-shot width", n, 6);
        @(posedge clk); #1;

        // R10: pulse train with alternating preloads
        tick_en = 1'b0;
        wr(2'd2, 16'h3E84);
        wr(2'd0, 16'd3); wr(2'd1, 16'h0000);
        wr(2'd2, 16'h7E84);
        wr(2'd0, 16'd2); wr(2'd1, 16'h0000);
        wr(2'd2, 16'h3E84);
        wr(2'd3, 16'h4008);
        tick_en = 1'b1;
        while (cnt_out !== 1'b0) @(negedge clk);
        while (cnt_out !== 1'b1) @(negedge clk);
        n = 0;
        while (cnt_out === 1'b1 && n < 50) begin n++; @(negedge clk); end
        check("R10 high phase", n, 3);
        n = 0;
        while (cnt_out === 1'b0 && n < 50) begin n++; @(negedge clk); end
        check("R10 low phase", n, 4);
        @(posedge clk); #1;

        // R8: load command swept against terminal counts
        cur_req = "R8";
        for (int k = 0; k < 8; k++) begin
            idle(k);
            wr(2'd3, 16'h4000);
        end
        idle(10);

        // R11: terminal-count pulse, inverted
        cur_req = "R11";
        wr(2'd2, 16'h3E87);
        @(negedge clk);
        while (cnt_out !== 1'b0) @(negedge clk);
        @(negedge clk);
        check("R11 tc pulse width", int'(cnt_out), 1);
        @(posedge clk); #1;

        // R10: wrap when reload field is 0
        cur_req = "R10";
        tick_en = 1'b0;
        wr(2'd2, 16'h3E80); wr(2'd3, 16'h8008);
        tick_en = 1'b1; @(posedge clk); #1 tick_en = 1'b0;
        peek(2'd1, d); check("R10 wrap high", int'(d), 'hFF);
        peek(2'd0, d); check("R10 wrap low", int'(d), 'hFFFF);
        check("R10 wrap flag", int'(cnt_out), 1);

        // R7: enable off, then index-level gating
        cur_req = "R7";
        wr(2'd2, 16'h3E00);
        tick_en = 1'b1; idle(3); tick_en = 1'b0;
        peek(2'd0, d); check("R7 enable off", int'(d), 'hFFFF);
        wr(2'd2, 16'h3720); wr(2'd3, 16'h8000);
        tick_en = 1'b1; idle(5);
        peek(2'd0, d); check("R7 gate closed", int'(d), 0);
        enc_idx = 1'b1; idle(6); enc_idx = 1'b0; idle(4);
        tick_en = 1'b0;
        peek(2'd0, d); check("R7 gate by index", int'(d), 6);

        idle(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule